// File: doc/BRIEF.md
# PRBS7 Link Self-Test Checker

This block sits behind a serial link receiver and judges an at-speed self-test of that link. While the test enable input is high, every valid 24-bit payload word is compared against a pseudo-random sequence (PRBS7). The first valid word after the enable rises seeds the checker's own sequence generator. Each later word is compared with the 24 bits the generator predicts.

The single `pass` output serves two purposes. In one mode it reports only the overall verdict. In the other mode it also drops low for half a clock period for each payload that contains errors, so an external counter can measure the payload error rate. The length of the test is set by how long the enable stays high. When the enable falls, checking stops and the verdict stays on `pass` until the next run, or until reset.

Top module: `prbs_bist_checker`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pass` is high and no errored payload is recorded.
- R2: The reference sequence obeys b[n] = b[n-7] xor b[n-6] (polynomial x^7 + x^6 + 1). Within a payload, bit 23 is the earliest and bit 0 the latest. The first valid payload after the enable rises is not checked; its bits [6:0] seed the sequence. Each later valid payload is compared with the next 24 predicted bits.
- R3: A checked payload whose bits differ from the prediction in anywhere from 1 to 24 positions counts as exactly one errored payload.
- R4: If `bist_mode` is 1 at the edge where an errored payload is taken, `pass` is low during the low phase of the following clock cycle only. Otherwise `pass` stays high while the test runs.
- R5: If `bist_mode` is 0, `pass` stays high throughout the run, whether or not errors occur.
- R6: From the cycle after the edge that samples `bist_en` low, `pass` is high if the run saw no errored payload and low if it saw one or more.
- R7: While `bist_en` stays low, neither payloads nor `bist_mode` change the held verdict.
- R8: A rising edge of `bist_en` clears the recorded verdict, and `pass` is high from the next cycle.
- R9: Cycles in which `payload_valid` is low are not checked and do not advance the reference sequence.
- R10: Asserting `rst_n` low while a failing verdict is held returns `pass` to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_en | input | 1 | Test enable; the test runs while it is high |
| bist_mode | input | 1 | 1 = also pulse for each errored payload, 0 = verdict only |
| payload | input | 24 | Received payload word, bit 23 earliest |
| payload_valid | input | 1 | Marks a cycle carrying a payload |
| pass | output | 1 | Error pulses and the held verdict |

## Verification
An error-free stream shows that both the prediction and the bit order are right, because any mismatch would pull the verdict low. Single-bit and fully inverted payloads show that any error weight counts as one errored payload and produces one pulse. Gaps in `payload_valid`, and seeding from an arbitrary point in the sequence, separate a checker that advances only on data from one that advances on every cycle or expects a fixed start state. Erroneous traffic sent while the enable is low, a reset and a new run then show when the verdict is held, cleared or reset. Both clock phases are sampled, so the half-cycle pulse is told apart from the level verdict.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

   localparam int unsigned PRBS7_ORDER = 7;
   localparam int unsigned PRBS7_TAP   = 6;

   typedef enum logic {
      PULSE_HALF_CYCLE = 1'b0,
      PULSE_FULL_CYCLE = 1'b1
   } pulse_style_e;

endpackage

// File: rtl/prbs_bist_predict.sv
module prbs_bist_predict #(
   parameter int unsigned WIDTH = 24,
   parameter int unsigned ORDER = 7,
   parameter int unsigned TAP   = 6
) (
   input  logic [ORDER-1:0] state_i,
   output logic [WIDTH-1:0] expect_o,
   output logic [ORDER-1:0] state_next_o
);

   if (TAP < 1 || TAP >= ORDER) begin : g_bad_tap
      $error("prbs_bist_predict: TAP must lie in 1..ORDER-1");
   end
   if (WIDTH < ORDER) begin : g_bad_width
      $error("prbs_bist_predict: WIDTH must be at least ORDER");
   end

   logic [ORDER-1:0] chain [0:WIDTH];

   assign chain[0] = state_i;

   for (genvar j = 0; j < WIDTH; j++) begin : g_step
      logic nb;
      assign nb           = chain[j][ORDER-1] ^ chain[j][TAP-1];
      assign chain[j+1]   = {chain[j][ORDER-2:0], nb};
      assign expect_o[WIDTH-1-j] = nb;
   end

   assign state_next_o = chain[WIDTH];

endmodule

// File: rtl/prbs_bist_track.sv
module prbs_bist_track #(
   parameter int unsigned WIDTH = 24,
   parameter int unsigned ORDER = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bist_en,
   input  logic             bist_mode,
   input  logic             payload_valid,
   input  logic [WIDTH-1:0] payload,
   input  logic [WIDTH-1:0] expect_i,
   input  logic [ORDER-1:0] state_next_i,
   output logic [ORDER-1:0] ref_state_o,
   output logic             en_q_o,
   output logic             err_flag_o,
   output logic             pulse_o
);

   logic seeded_q;
   logic mismatch;
   logic en_rise;

   assign mismatch = |(payload ^ expect_i);
   assign en_rise  = bist_en & ~en_q_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q_o      <= 1'b0;
         seeded_q    <= 1'b0;
         ref_state_o <= '0;
         err_flag_o  <= 1'b0;
         pulse_o     <= 1'b0;
      end else begin
         en_q_o  <= bist_en;
         pulse_o <= 1'b0;
         if (!bist_en) begin
            seeded_q <= 1'b0;
         end else if (payload_valid) begin
            if (!seeded_q) begin
               ref_state_o <= payload[ORDER-1:0];
               seeded_q    <= 1'b1;
            end else begin
               ref_state_o <= state_next_i;
               if (mismatch) begin
                  err_flag_o <= 1'b1;
                  pulse_o    <= bist_mode;
               end
            end
         end
         if (en_rise) begin
            err_flag_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/prbs_bist_pass_out.sv
module prbs_bist_pass_out
   import prbs_bist_pkg::*;
#(
   parameter pulse_style_e STYLE = PULSE_HALF_CYCLE
) (
   input  logic clk,
   input  logic en_q,
   input  logic err_flag,
   input  logic pulse,
   output logic pass
);

   logic level;

   assign level = en_q | ~err_flag;

   if (STYLE == PULSE_HALF_CYCLE) begin : g_half
      assign pass = level & ~(pulse & ~clk);
   end else begin : g_full
      logic unused_clk;
      assign unused_clk = clk;
      assign pass = level & ~pulse;
   end

endmodule

// File: rtl/prbs_bist_checker.sv
module prbs_bist_checker
   import prbs_bist_pkg::*;
#(
   parameter int unsigned  WIDTH = 24,
   parameter int unsigned  ORDER = PRBS7_ORDER,
   parameter int unsigned  TAP   = PRBS7_TAP,
   parameter pulse_style_e STYLE = PULSE_HALF_CYCLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bist_en,
   input  logic             bist_mode,
   input  logic [WIDTH-1:0] payload,
   input  logic             payload_valid,
   output logic             pass
);

   logic [ORDER-1:0] ref_state;
   logic [ORDER-1:0] state_next;
   logic [WIDTH-1:0] expect_bits;
   logic             en_q;
   logic             err_flag;
   logic             pulse_q;

   prbs_bist_predict #(
      .WIDTH (WIDTH),
      .ORDER (ORDER),
      .TAP   (TAP)
   ) u_predict (
      .state_i      (ref_state),
      .expect_o     (expect_bits),
      .state_next_o (state_next)
   );

   prbs_bist_track #(
      .WIDTH (WIDTH),
      .ORDER (ORDER)
   ) u_track (
      .clk           (clk),
      .rst_n         (rst_n),
      .bist_en       (bist_en),
      .bist_mode     (bist_mode),
      .payload_valid (payload_valid),
      .payload       (payload),
      .expect_i      (expect_bits),
      .state_next_i  (state_next),
      .ref_state_o   (ref_state),
      .en_q_o        (en_q),
      .err_flag_o    (err_flag),
      .pulse_o       (pulse_q)
   );

   prbs_bist_pass_out #(
      .STYLE (STYLE)
   ) u_pass_out (
      .clk      (clk),
      .en_q     (en_q),
      .err_flag (err_flag),
      .pulse    (pulse_q),
      .pass     (pass)
   );

endmodule

// File: rtl/prbs_bist_checker_sva.sv
module prbs_bist_checker_sva #(
   parameter int unsigned ORDER = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bist_en,
   input logic             bist_mode,
   input logic             payload_valid,
   input logic             en_q,
   input logic             err_flag,
   input logic             pulse_q,
   input logic [ORDER-1:0] ref_state
);

   AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en && !en_q) |=> !err_flag); // R8

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bist_en |=> $stable(err_flag)); // R7

   AST_PULSE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> ($past(bist_mode) && $past(bist_en) && $past(payload_valid))); // R4

   AST_PULSE_MARKS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> err_flag); // R3

   AST_GAP_FREEZES_REF: assert property (@(posedge clk) disable iff (!rst_n)
      !payload_valid |=> $stable(ref_state)); // R9

endmodule

bind prbs_bist_checker prbs_bist_checker_sva #(.ORDER(ORDER)) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .bist_en       (bist_en),
   .bist_mode     (bist_mode),
   .payload_valid (payload_valid),
   .en_q          (en_q),
   .err_flag      (err_flag),
   .pulse_q       (pulse_q),
   .ref_state     (ref_state)
);

// File: tb/prbs_bist_checker_tb.sv
module prbs_bist_checker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bist_en = 1'b0;
   logic        bist_mode = 1'b0;
   logic [23:0] payload = '0;
   logic        payload_valid = 1'b0;
   logic        pass;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // stream generator history and reference model state
   bit gen_hist[$];
   bit m_ref[$];
   bit m_en_q = 1'b0;
   bit m_seeded = 1'b0;
   bit m_flag = 1'b0;
   bit m_pulse = 1'b0;

   always #2 clk = ~clk;

   prbs_bist_checker u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bist_en       (bist_en),
      .bist_mode     (bist_mode),
      .payload       (payload),
      .payload_valid (payload_valid),
      .pass          (pass)
   );

   function automatic logic [23:0] next_word();
      logic [23:0] w;
      for (int j = 0; j < 24; j++) begin
         bit nb;
         nb = gen_hist[gen_hist.size()-7] ^ gen_hist[gen_hist.size()-6];
         gen_hist.push_back(nb);
         w[23-j] = nb;
      end
      while (gen_hist.size() > 7) void'(gen_hist.pop_front());
      return w;
   endfunction

   task automatic model_update();
      bit rise;
      bit new_pulse;
      if (!rst_n) begin
         m_en_q = 0; m_seeded = 0; m_flag = 0; m_pulse = 0;
         return;
      end
      rise = bist_en && !m_en_q;
      new_pulse = 0;
      if (!bist_en) begin
         m_seeded = 0;
      end else if (payload_valid) begin
         if (!m_seeded) begin
            m_ref.delete();
            for (int k = 6; k >= 0; k--) m_ref.push_back(payload[k]);
            m_seeded = 1;
         end else begin
            bit bad;
            bad = 0;
            for (int j = 0; j < 24; j++) begin
               bit e;
               e = m_ref[m_ref.size()-7] ^ m_ref[m_ref.size()-6];
               m_ref.push_back(e);
               if (e != payload[23-j]) bad = 1;
            end
            while (m_ref.size() > 7) void'(m_ref.pop_front());
            if (bad) begin
               m_flag = 1;
               new_pulse = bist_mode;
            end
         end
      end
      if (rise) m_flag = 0;
      m_pulse = new_pulse;
      m_en_q = bist_en;
   endtask

   task automatic step(input bit en, input bit mode, input bit vld,
                       input logic [23:0] pl, input string tag);
      bit exp_hi;
      bit exp_lo;
      bist_en = en;
      bist_mode = mode;
      payload_valid = vld;
      payload = pl;
      @(posedge clk);
      model_update();
      exp_hi = m_en_q ? 1'b1 : !m_flag;
      exp_lo = exp_hi & !m_pulse;
      #1;
      checks++;
      if (pass !== exp_hi) begin
         fails++;
         $display("FAIL %s high-phase pass=%b expected=%b at %0t", tag, pass, exp_hi, $time);
      end
      #2;
      checks++;
      if (pass !== exp_lo) begin
         fails++;
         $display("FAIL %s low-phase pass=%b expected=%b at %0t", tag, pass, exp_lo, $time);
      end
   endtask

   task automatic run_clean(input bit mode, input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, mode, 1, next_word(), tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, i[0], 1, 24'($urandom), tag);
   endtask

   initial begin
      gen_hist = '{1, 0, 0, 1, 0, 1, 1};

      // R1: reset state
      for (int i = 0; i < 3; i++) step(0, 0, 0, '0, "R1");
      rst_n = 1'b1;
      step(0, 0, 0, '0, "R1");

      // R2 R6: clean run, verdict-only mode
      run_clean(0, 12, "R2");
      idle(3, "R6");

      // R5 R3 R9: error during verdict-only run, with gaps
      run_clean(0, 4, "R5");
      step(1, 0, 1, next_word() ^ 24'h000001, "R3");
      run_clean(0, 2, "R5");
      step(1, 0, 0, 24'hABCDEF, "R9");
      step(1, 0, 0, 24'h123456, "R9");
      run_clean(0, 3, "R9");
      idle(2, "R6");
      // R7: random traffic and mode changes while idle
      idle(6, "R7");

      // R8: new run clears verdict; R4: pulse mode
      run_clean(1, 3, "R8");
      step(1, 1, 1, next_word() ^ 24'hFFFFFF, "R4");
      run_clean(1, 2, "R4");
      step(1, 1, 1, next_word() ^ 24'h800000, "R3");
      step(1, 1, 0, 24'h0, "R9");
      run_clean(1, 2, "R4");
      step(1, 0, 1, next_word() ^ 24'h010000, "R5");
      run_clean(1, 2, "R4");
      idle(3, "R6");

      // R2: seed from an arbitrary point of the stream
      for (int i = 0; i < 5; i++) void'(next_word());
      run_clean(1, 10, "R2");
      idle(2, "R6");

      // R10: reset during a held failing verdict
      run_clean(0, 3, "R10");
      step(1, 0, 1, next_word() ^ 24'h00F000, "R10");
      idle(2, "R10");
      rst_n = 1'b0;
      step(0, 0, 0, '0, "R10");
      rst_n = 1'b1;
      idle(3, "R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule